// File: doc/BRIEF.md
# Multi-Mode Quadrature Encoder Counter

This block keeps a position count for each of three incremental encoder channels. Every channel has two phase inputs, A and B. Both are brought into the clock domain through two-flop synchronizers. Each single-phase change is then classified as one of eight numbered transitions. One global mode decides which transitions count up and which count down. The mode sets the input type (quadrature or single-phase), the multiplier (x1, x2 or x4) and the direction (normal or reverse).

The host controls the block with one command byte. A command can snapshot one counter into a shared holding register, clear one counter, or load the mode. The counters cannot be read directly. The host always latches a counter first and then reads the holding register one byte at a time, using a byte select, in either order.

Top module: `quad_enc_counter`

## Requirements
- R1: A command is taken when `cmdValid` is high. Bits [3:2] give the operation: 00 latches a counter, 01 clears a counter, and 1x loads the mode. Bits [1:0] select the channel. For a mode load, the new mode is {bit2, bit1, bit0}. Bits [7:4] are ignored.
- R2: A latch or clear command with channel select 3 changes neither any counter nor the holding register.
- R3: Transitions are numbered as follows. Rising A with B low is 1, rising B with A high is 2, falling A with B high is 3 and falling B with A low is 4. Rising B with A low is 5, rising A with B high is 6, falling B with A high is 7 and falling A with B low is 8. In mode 0 (quadrature x2), transitions 6 and 8 count up and transitions 1 and 3 count down.
- R4: Mode 1 (x4) counts up on transitions 5 to 8 and down on 1 to 4. Mode 2 (x1) counts up on 8 and down on 1.
- R5: Mode 3 (single-phase) counts down on transition 1 and ignores every other transition.
- R6: Modes 4 to 7 behave as modes 0 to 3 with the up and down sets exchanged.
- R7: A counter wraps from 0xFFFF to 0x0000 when counting up and from 0x0000 to 0xFFFF when counting down.
- R8: A latch command copies the selected counter into the holding register at the command's clock edge. The value then stays unchanged until the next latch. `rdByte` shows bits [7:0] when `byteSel`=0 and bits [15:8] when `byteSel`=1, and the two bytes can be read in either order.
- R9: A clear command zeroes only the selected counter. The next valid transition on that channel is counted from zero.
- R10: Either `rstN` low or a `softRst` pulse zeroes all counters and the holding register, and sets mode 0.
- R11: A latch taken in the same cycle as a count event on that channel captures the value from before the count. The count appears at the next latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low hard reset |
| softRst | input | 1 | Synchronous local reset pulse |
| phaseA | input | 3 | Phase A input of each channel |
| phaseB | input | 3 | Phase B input of each channel |
| cmdValid | input | 1 | Command strobe |
| cmdByte | input | 8 | Command byte |
| byteSel | input | 1 | Selects the holding-register byte: 0 low, 1 high |
| rdByte | output | 8 | Selected byte of the holding register |

## Verification
Two things can happen in the same cycle: a count event on a channel, and a latch of that same channel. The bench forces this collision by timing the latch. It moves one phase input, waits exactly the two synchronizer stages and the edge-detect stage, and then issues the latch command so that it lands on the clock edge where the counter steps. The holding register must show the value from before the step. A second latch must then show the stepped value, which confirms the event was counted and not lost.

// File: rtl/enc_pkg.sv
package enc_pkg;
  localparam int ENC_CH   = 3;
  localparam int ENC_CW   = 16;
  localparam int ENC_SELW = 2;

  typedef struct packed {
    logic                latch;
    logic                clr;
    logic                modeSet;
    logic [ENC_SELW-1:0] sel;
  } enc_strobe_t;

  // Returns {up, down} for one sampled step of a channel.
  function automatic logic [1:0] stepDir(input logic [2:0] mode,
                                         input logic a0, input logic b0,
                                         input logic a1, input logic b1);
    logic [7:0] tr;
    logic [7:0] upM;
    logic [7:0] dnM;
    logic [7:0] tmp;
    tr[0] = !a0 &  a1 & !b0 & !b1;  // t1
    tr[1] =  a0 &  a1 & !b0 &  b1;  // t2
    tr[2] =  a0 & !a1 &  b0 &  b1;  // t3
    tr[3] = !a0 & !a1 &  b0 & !b1;  // t4
    tr[4] = !a0 & !a1 & !b0 &  b1;  // t5
    tr[5] = !a0 &  a1 &  b0 &  b1;  // t6
    tr[6] =  a0 &  a1 &  b0 & !b1;  // t7
    tr[7] =  a0 & !a1 & !b0 & !b1;  // t8
    case (mode[1:0])
      2'd0:    begin upM = 8'b1010_0000; dnM = 8'b0000_0101; end
      2'd1:    begin upM = 8'b1111_0000; dnM = 8'b0000_1111; end
      2'd2:    begin upM = 8'b1000_0000; dnM = 8'b0000_0001; end
      default: begin upM = 8'b0000_0000; dnM = 8'b0000_0001; end
    endcase
    if (mode[2]) begin
      tmp = upM;
      upM = dnM;
      dnM = tmp;
    end
    return {|(tr & upM), |(tr & dnM)};
  endfunction
endpackage

// File: rtl/enc_ctrl.sv
module enc_ctrl
  import enc_pkg::*;
#(
  parameter int NCH = ENC_CH
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        softRst,
  input  logic        cmdValid,
  input  logic [7:0]  cmdByte,
  output enc_strobe_t strobe,
  output logic [2:0]  modeReg
);
  logic [1:0] opCode;
  logic       selOk;

  assign opCode = cmdByte[3:2];
  assign selOk  = (int'(cmdByte[1:0]) < NCH);

  always_comb begin
    strobe         = '0;
    strobe.sel     = cmdByte[ENC_SELW-1:0];
    strobe.latch   = cmdValid && (opCode == 2'b00) && selOk;
    strobe.clr     = cmdValid && (opCode == 2'b01) && selOk;
    strobe.modeSet = cmdValid && opCode[1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              modeReg <= 3'd0;
    else if (softRst)       modeReg <= 3'd0;
    else if (strobe.modeSet) modeReg <= cmdByte[2:0];
  end
endmodule

// File: rtl/enc_datapath.sv
module enc_datapath
  import enc_pkg::*;
#(
  parameter int NCH = ENC_CH,
  parameter int CW  = ENC_CW
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           softRst,
  input  logic [NCH-1:0] phaseA,
  input  logic [NCH-1:0] phaseB,
  input  enc_strobe_t    strobe,
  input  logic [2:0]     modeReg,
  output logic [CW-1:0]  holdVal
);
  logic [NCH-1:0] aMeta, aSync, aPrev;
  logic [NCH-1:0] bMeta, bSync, bPrev;
  logic [NCH-1:0] stepUp, stepDn;
  logic [CW-1:0]  cntArr [NCH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aMeta <= '0; aSync <= '0; aPrev <= '0;
      bMeta <= '0; bSync <= '0; bPrev <= '0;
    end else if (softRst) begin
      aMeta <= '0; aSync <= '0; aPrev <= '0;
      bMeta <= '0; bSync <= '0; bPrev <= '0;
    end else begin
      aMeta <= phaseA; aSync <= aMeta; aPrev <= aSync;
      bMeta <= phaseB; bSync <= bMeta; bPrev <= bSync;
    end
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    logic [1:0] dir;
    assign dir        = stepDir(modeReg, aPrev[ch], bPrev[ch], aSync[ch], bSync[ch]);
    assign stepUp[ch] = dir[1];
    assign stepDn[ch] = dir[0];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        cntArr[ch] <= '0;
      else if (softRst || (strobe.clr && (int'(strobe.sel) == ch)))
        cntArr[ch] <= '0;
      else if (stepUp[ch])
        cntArr[ch] <= cntArr[ch] + 1'b1;
      else if (stepDn[ch])
        cntArr[ch] <= cntArr[ch] - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             holdVal <= '0;
    else if (softRst)      holdVal <= '0;
    else if (strobe.latch) holdVal <= cntArr[strobe.sel];
  end
endmodule

// File: rtl/quad_enc_counter.sv
module quad_enc_counter
  import enc_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         softRst,
  input  logic [2:0]   phaseA,
  input  logic [2:0]   phaseB,
  input  logic         cmdValid,
  input  logic [7:0]   cmdByte,
  input  logic         byteSel,
  output logic [7:0]   rdByte
);
  enc_strobe_t         ctrlS;
  logic [2:0]          modeReg;
  logic [ENC_CW-1:0]   holdVal;

  enc_ctrl #(.NCH(ENC_CH)) ctrl_i (
    .clk(clk), .rstN(rstN), .softRst(softRst),
    .cmdValid(cmdValid), .cmdByte(cmdByte),
    .strobe(ctrlS), .modeReg(modeReg)
  );

  enc_datapath #(.NCH(ENC_CH), .CW(ENC_CW)) dp_i (
    .clk(clk), .rstN(rstN), .softRst(softRst),
    .phaseA(phaseA), .phaseB(phaseB),
    .strobe(ctrlS), .modeReg(modeReg),
    .holdVal(holdVal)
  );

  assign rdByte = byteSel ? holdVal[15:8] : holdVal[7:0];
endmodule

// File: rtl/enc_checker.sv
module enc_checker
  import enc_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              softRst,
  input logic              cmdValid,
  input logic [7:0]        cmdByte,
  input enc_strobe_t       ctrlS,
  input logic [2:0]        modeReg,
  input logic [ENC_CW-1:0] holdVal
);
  a_r1_strobe_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctrlS.latch, ctrlS.clr, ctrlS.modeSet}));

  a_r2_reserved_noop: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdByte[3] && cmdByte[1:0] == 2'b11) |-> (!ctrlS.latch && !ctrlS.clr));

  a_r6_mode_load: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdByte[3] && !softRst) |=> (modeReg == $past(cmdByte[2:0])));

  a_r6_mode_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!(cmdValid && cmdByte[3]) && !softRst) |=> $stable(modeReg));

  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlS.latch && !softRst) |=> $stable(holdVal));

  a_r10_soft_clear: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> (holdVal == '0 && modeReg == 3'd0));
endmodule

bind quad_enc_counter enc_checker chk_i (
  .clk(clk), .rstN(rstN), .softRst(softRst),
  .cmdValid(cmdValid), .cmdByte(cmdByte),
  .ctrlS(ctrlS), .modeReg(modeReg), .holdVal(holdVal)
);

// File: tb/quad_enc_counter_tb.sv
module quad_enc_counter_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       softRst = 1'b0;
  logic [2:0] phaseA = '0;
  logic [2:0] phaseB = '0;
  logic       cmdValid = 1'b0;
  logic [7:0] cmdByte = '0;
  logic       byteSel = 1'b0;
  logic [7:0] rdByte;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;  // 250 MHz

  quad_enc_counter dut_i (
    .clk(clk), .rstN(rstN), .softRst(softRst),
    .phaseA(phaseA), .phaseB(phaseB),
    .cmdValid(cmdValid), .cmdByte(cmdByte),
    .byteSel(byteSel), .rdByte(rdByte)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doCmd(input logic [7:0] c);
    @(negedge clk); cmdValid = 1'b1; cmdByte = c;
    @(negedge clk); cmdValid = 1'b0; cmdByte = '0;
  endtask

  task automatic readHold(output logic [15:0] v, input bit hiFirst);
    logic [7:0] lo, hi;
    if (hiFirst) begin
      byteSel = 1'b1; #0.5 hi = rdByte;
      byteSel = 1'b0; #0.5 lo = rdByte;
    end else begin
      byteSel = 1'b0; #0.5 lo = rdByte;
      byteSel = 1'b1; #0.5 hi = rdByte;
    end
    v = {hi, lo};
  endtask

  task automatic expectCnt(input int ch, input logic [15:0] exp, input string tag);
    logic [15:0] v;
    doCmd({6'b0, ch[1:0]});
    readHold(v, 1'b0);
    check(tag, v, exp);
  endtask

  task automatic setPh(input int ch, input bit a, input bit b);
    @(negedge clk); phaseA[ch] = a; phaseB[ch] = b;
    repeat (4) @(negedge clk);
  endtask

  // forward walk: t1, t2, t3, t4
  task automatic fwdCycle(input int ch);
    setPh(ch, 1, 0); setPh(ch, 1, 1); setPh(ch, 0, 1); setPh(ch, 0, 0);
  endtask

  // backward walk: t5, t6, t7, t8
  task automatic revCycle(input int ch);
    setPh(ch, 0, 1); setPh(ch, 1, 1); setPh(ch, 1, 0); setPh(ch, 0, 0);
  endtask

  task automatic testReset();
    logic [15:0] v;
    readHold(v, 1'b0);
    check("R10 hold after hard reset", v, 16'h0000);
    for (int c = 0; c < 3; c++) expectCnt(c, 16'h0000, "R10 counter after hard reset");
  endtask

  task automatic testMode0();
    fwdCycle(0);
    expectCnt(0, 16'hFFFE, "R3 R7 mode0 forward x2 with down wrap");
    revCycle(0);
    expectCnt(0, 16'h0000, "R3 R7 mode0 backward x2 with up wrap");
  endtask

  task automatic testMode12();
    doCmd(8'h09);
    fwdCycle(1);
    expectCnt(1, 16'hFFFC, "R4 mode1 forward x4");
    revCycle(1); revCycle(1);
    expectCnt(1, 16'h0004, "R4 mode1 backward x4");
    doCmd(8'h0A);
    fwdCycle(2);
    expectCnt(2, 16'hFFFF, "R4 mode2 forward x1");
    revCycle(2); revCycle(2);
    expectCnt(2, 16'h0001, "R4 R7 mode2 backward x1 across wrap");
  endtask

  task automatic testMode3();
    doCmd(8'h0B);
    fwdCycle(0);
    expectCnt(0, 16'hFFFF, "R5 single phase counts t1 down");
    revCycle(0);
    expectCnt(0, 16'hFFFF, "R5 single phase ignores t5 to t8");
  endtask

  task automatic testReverse();
    doCmd(8'h0D);
    fwdCycle(1);
    expectCnt(1, 16'h0008, "R6 mode5 reversed x4");
    doCmd(8'h0F);
    fwdCycle(1);
    expectCnt(1, 16'h0009, "R6 mode7 reversed single phase");
    doCmd(8'h0C);
    revCycle(1);
    expectCnt(1, 16'h0007, "R6 mode4 reversed x2");
  endtask

  task automatic testReserved();
    logic [15:0] v;
    expectCnt(2, 16'h0001, "R8 latch channel 2");
    doCmd(8'h03);
    readHold(v, 1'b0);
    check("R2 latch of channel 3 leaves hold", v, 16'h0001);
    doCmd(8'h07);
    expectCnt(0, 16'hFFFF, "R2 clear of channel 3 keeps ch0");
    expectCnt(1, 16'h0007, "R2 clear of channel 3 keeps ch1");
    expectCnt(2, 16'h0001, "R2 clear of channel 3 keeps ch2");
  endtask

  task automatic testUpperAndClear();
    logic [15:0] v;
    doCmd(8'hF1);
    readHold(v, 1'b0);
    check("R1 upper bits ignored on latch", v, 16'h0007);
    doCmd(8'h55);
    expectCnt(1, 16'h0000, "R9 clear zeroes ch1");
    expectCnt(0, 16'hFFFF, "R9 clear leaves ch0");
    fwdCycle(1);
    expectCnt(1, 16'h0002, "R9 counting resumes after clear");
  endtask

  task automatic testHoldStable();
    logic [15:0] v;
    doCmd(8'h00);
    fwdCycle(1);
    readHold(v, 1'b1);
    check("R8 hold unchanged while counting, high byte first", v, 16'hFFFF);
    readHold(v, 1'b0);
    check("R8 hold low byte first", v, 16'hFFFF);
    expectCnt(1, 16'h0004, "R8 fresh latch sees new count");
  endtask

  task automatic testSameCycle();
    logic [15:0] v;
    // mode 4 active: t1 counts up on channel 2
    @(negedge clk); phaseA[2] = 1'b1;   // before edge E1
    @(negedge clk);                     // E1: first sync stage
    @(negedge clk); cmdValid = 1'b1; cmdByte = 8'h02; // E3 is the count edge
    @(negedge clk); cmdValid = 1'b0; cmdByte = '0;
    readHold(v, 1'b0);
    check("R11 latch with count captures old value", v, 16'h0001);
    expectCnt(2, 16'h0002, "R11 count not lost");
    setPh(2, 0, 0);
  endtask

  task automatic testSoftReset();
    logic [15:0] v;
    @(negedge clk); softRst = 1'b1;
    @(negedge clk); softRst = 1'b0;
    readHold(v, 1'b0);
    check("R10 soft reset clears hold", v, 16'h0000);
    for (int c = 0; c < 3; c++) expectCnt(c, 16'h0000, "R10 soft reset clears counter");
    fwdCycle(0);
    expectCnt(0, 16'hFFFE, "R10 soft reset returns to mode0");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testMode0();
    testMode12();
    testMode3();
    testReverse();
    testReserved();
    testUpperAndClear();
    testHoldStable();
    testSameCycle();
    testSoftReset();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule